// File: doc/BRIEF.md
# Averaging Threshold Comparator

This block sits behind a measurement engine that delivers raw integer conversion results one at a time. It adds up a selectable number of consecutive samples (1, 4, 8, 16, 32 or 64) into one conversion. It divides the sum by the sample count to form a 16-bit average and hands that average downstream as one result. Each result is also compared with a 16-bit unsigned threshold. A polarity input chooses between a strict greater-than test and a less-than-or-equal test. When the test passes and comparison is enabled, a one-clock compare event is raised in the cycle the result is taken.

Samples enter on a valid/ready stream and results leave on a valid/ready stream. A sample transfers on a clock edge where `in_valid` and `in_ready` are both high. A result transfers on an edge where `out_valid` and `out_ready` are both high. Once `out_valid` rises it stays high and `out_result` stays fixed until the result is taken. While a result is waiting and `out_ready` is low, `in_ready` is low and no sample is accepted. The block holds one finished result; the conversion in progress does not advance while that result is blocked. Threshold, polarity and enable are plain control inputs. They are captured together with the final sample of a conversion, so a later change does not affect a result that is already waiting.

Top module: `avg_threshold_comparator`

## Requirements
- R1: After reset `out_valid`, `cmp_event` and `out_result` are 0 and `in_ready` is 1.
- R2: `count_sel` chooses the samples per conversion: 0 gives 1, 1 gives 4, 2 gives 8, 3 gives 16, 4 gives 32, 5 gives 64, and 6 or 7 give 1. The value is taken with the first sample of a conversion; changing it later in that conversion has no effect.
- R3: `out_result` equals the unsigned sum of the conversion's samples divided by the sample count, rounded down. A full sum of 64 samples of 65535 gives 65535.
- R4: `out_valid` rises in the cycle after the final sample of a conversion is accepted. It then holds, with `out_result` unchanged, until a cycle with `out_ready` high. With `out_ready` held high it lasts exactly one cycle.
- R5: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and no sample is accepted.
- R6: With polarity 0, a result raises the event only if it is strictly greater than the threshold. A result equal to the threshold does not raise it.
- R7: With polarity 1, a result raises the event if it is less than or equal to the threshold.
- R8: When compare enable is 0 at the final sample, that result raises no event.
- R9: `cmp_event` is high for exactly the handshake cycle of a result that matched. It uses the threshold, polarity and enable captured at the final sample of that conversion.
- R10: Every conversion starts from a zero sum; no earlier sample contributes to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Sample can be accepted |
| in_sample | input | 16 | Unsigned sample value |
| count_sel | input | 3 | Samples-per-conversion code |
| cmp_polarity | input | 1 | 0: greater-than test, 1: less-or-equal test |
| cmp_enable | input | 1 | Allows compare events |
| cmp_threshold | input | 16 | Unsigned compare threshold |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Downstream takes the result |
| out_result | output | 16 | Averaged result |
| cmp_event | output | 1 | Compare match, one clock at the result handshake |

## Verification
The bound checker watches the stream rules on every cycle: input back-pressure while a result is blocked, and a stable result while it waits. It also checks that an event appears only in a handshake cycle. Any event must agree with the captured enable, polarity and threshold. What the checker cannot show is the arithmetic: the sample count chosen by each code, the rounded-down average, the full-scale sum, and the fresh start of each conversion. These, together with the equal-to-threshold boundary and events that are correctly absent, come only from the bench scenarios checked against its reference model.

// File: rtl/avgcmp_pkg.sv
`timescale 1ns/1ps
package avgcmp_pkg;
  localparam int SEL_W    = 3;
  localparam int MAX_LOG2 = 6;
  localparam int LG_W     = 3;

  // Map the samples-per-conversion code to log2 of the sample count.
  function automatic logic [LG_W-1:0] count_log2(input logic [SEL_W-1:0] sel);
    logic [LG_W-1:0] lg;
    case (sel)
      3'd1:    lg = 3'd2;
      3'd2:    lg = 3'd3;
      3'd3:    lg = 3'd4;
      3'd4:    lg = 3'd5;
      3'd5:    lg = 3'd6;
      default: lg = 3'd0;   // codes 0, 6, 7: one sample
    endcase
    return lg;
  endfunction
endpackage

// File: rtl/avg_accumulator.sv
`timescale 1ns/1ps
module avg_accumulator
  import avgcmp_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int RESULT_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [SEL_W-1:0]    count_sel,
  output logic                done,
  output logic [RESULT_W-1:0] avg
);
  localparam int ACC_W = SAMPLE_W + MAX_LOG2;
  localparam int CNT_W = MAX_LOG2;
  localparam int NSH   = 1 << LG_W;

  logic [CNT_W-1:0]    cnt_q;
  logic [ACC_W-1:0]    sum_q;
  logic [LG_W-1:0]     lg_q;
  logic                first;
  logic [LG_W-1:0]     lg_cur;
  logic [ACC_W-1:0]    next_sum;
  logic [CNT_W-1:0]    last_idx;
  logic                is_last;
  logic [RESULT_W-1:0] shifted [NSH];

  assign first    = (cnt_q == '0);
  assign lg_cur   = first ? count_log2(count_sel) : lg_q;
  assign next_sum = (first ? '0 : sum_q) + ACC_W'(sample);
  assign last_idx = ~({CNT_W{1'b1}} << lg_cur);
  assign is_last  = (cnt_q == last_idx);

  // One divider candidate per possible shift; lg_cur selects.
  for (genvar k = 0; k < NSH; k++) begin : g_shift
    assign shifted[k] = RESULT_W'(next_sum >> k);
  end

  assign avg  = shifted[lg_cur];
  assign done = accept && is_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sum_q <= '0;
      lg_q  <= '0;
    end else if (accept) begin
      lg_q <= lg_cur;
      if (is_last) begin
        cnt_q <= '0;
        sum_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        sum_q <= next_sum;
      end
    end
  end
endmodule

// File: rtl/avg_result_stage.sv
`timescale 1ns/1ps
module avg_result_stage #(
  parameter int RESULT_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [RESULT_W-1:0] load_data,
  input  logic                load_pol,
  input  logic                load_en,
  input  logic [RESULT_W-1:0] load_thr,
  input  logic                out_ready,
  output logic                out_valid,
  output logic                can_accept,
  output logic [RESULT_W-1:0] data_q,
  output logic                pol_q,
  output logic                en_q,
  output logic [RESULT_W-1:0] thr_q
);
  assign can_accept = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      data_q    <= '0;
      pol_q     <= 1'b0;
      en_q      <= 1'b0;
      thr_q     <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      data_q    <= load_data;
      pol_q     <= load_pol;
      en_q      <= load_en;
      thr_q     <= load_thr;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/avg_threshold_test.sv
`timescale 1ns/1ps
module avg_threshold_test #(
  parameter int W = 16
) (
  input  logic [W-1:0] value,
  input  logic [W-1:0] threshold,
  input  logic         polarity,
  input  logic         enable,
  output logic         hit
);
  logic above;
  assign above = value > threshold;
  assign hit   = enable && (polarity ? !above : above);
endmodule

// File: rtl/avg_threshold_comparator.sv
`timescale 1ns/1ps
module avg_threshold_comparator
  import avgcmp_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int RESULT_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  logic [SEL_W-1:0]    count_sel,
  input  logic                cmp_polarity,
  input  logic                cmp_enable,
  input  logic [RESULT_W-1:0] cmp_threshold,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [RESULT_W-1:0] out_result,
  output logic                cmp_event
);
  logic                accept;
  logic                conv_done;
  logic [RESULT_W-1:0] conv_avg;
  logic                pol_q;
  logic                en_q;
  logic [RESULT_W-1:0] thr_q;
  logic                hit;

  assign accept = in_valid && in_ready;

  avg_accumulator #(.SAMPLE_W(SAMPLE_W), .RESULT_W(RESULT_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .sample    (in_sample),
    .count_sel (count_sel),
    .done      (conv_done),
    .avg       (conv_avg)
  );

  avg_result_stage #(.RESULT_W(RESULT_W)) u_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (conv_done),
    .load_data  (conv_avg),
    .load_pol   (cmp_polarity),
    .load_en    (cmp_enable),
    .load_thr   (cmp_threshold),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .can_accept (in_ready),
    .data_q     (out_result),
    .pol_q      (pol_q),
    .en_q       (en_q),
    .thr_q      (thr_q)
  );

  avg_threshold_test #(.W(RESULT_W)) u_cmp (
    .value     (out_result),
    .threshold (thr_q),
    .polarity  (pol_q),
    .enable    (en_q),
    .hit       (hit)
  );

  assign cmp_event = out_valid && out_ready && hit;
endmodule

// File: rtl/avg_threshold_comparator_checker.sv
`timescale 1ns/1ps
module avg_threshold_comparator_checker #(
  parameter int RESULT_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_ready,
  input logic                out_valid,
  input logic                out_ready,
  input logic [RESULT_W-1:0] out_result,
  input logic                cmp_event,
  input logic                pol_q,
  input logic                en_q,
  input logic [RESULT_W-1:0] thr_q
);
  assert_backpressure_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_result_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)));

  assert_event_at_handshake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_event |-> (out_valid && out_ready));

  assert_event_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_event |-> en_q);

  assert_event_above_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_event && !pol_q) |-> (out_result > thr_q));

  assert_event_at_or_below_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_event && pol_q) |-> (out_result <= thr_q));
endmodule

bind avg_threshold_comparator avg_threshold_comparator_checker #(.RESULT_W(RESULT_W)) u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result),
  .cmp_event  (cmp_event),
  .pol_q      (pol_q),
  .en_q       (en_q),
  .thr_q      (thr_q)
);

// File: tb/avg_threshold_comparator_test.sv
`timescale 1ns/1ps
module avg_threshold_comparator_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_sample = '0;
  logic [2:0]  count_sel = '0;
  logic        cmp_polarity = 1'b0;
  logic        cmp_enable = 1'b0;
  logic [15:0] cmp_threshold = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_result;
  logic        cmp_event;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  avg_threshold_comparator uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .count_sel(count_sel), .cmp_polarity(cmp_polarity),
    .cmp_enable(cmp_enable), .cmp_threshold(cmp_threshold), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .cmp_event(cmp_event)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int samples_for(input int code);
    case (code)
      1: return 4;
      2: return 8;
      3: return 16;
      4: return 32;
      5: return 64;
      default: return 1;
    endcase
  endfunction

  // Behavioural reference model, advanced on each rising edge.
  int m_cnt = 0, m_n = 1, m_sum = 0, m_data = 0, m_thr = 0;
  bit m_valid = 0, m_pol = 0, m_en = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_sum = 0; m_valid = 0; m_data = 0;
      m_pol = 0; m_en = 0; m_thr = 0; m_n = 1;
    end else begin
      bit rdy;
      rdy = !m_valid || out_ready;
      if (m_valid && out_ready) m_valid = 0;
      if (in_valid && rdy) begin
        if (m_cnt == 0) begin
          m_n = samples_for(int'(count_sel));
          m_sum = 0;
        end
        m_sum += int'(in_sample);
        m_cnt++;
        if (m_cnt == m_n) begin
          m_data = m_sum / m_n;
          m_valid = 1;
          m_pol = cmp_polarity;
          m_en = cmp_enable;
          m_thr = int'(cmp_threshold);
          m_cnt = 0;
        end
      end
    end
  end

  function automatic bit model_hit();
    if (!m_en) return 0;
    return m_pol ? (m_data <= m_thr) : (m_data > m_thr);
  endfunction

  // Results seen at handshakes.
  int got_d[$];
  bit got_e[$];

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(out_valid == m_valid, "R4 out_valid", int'(out_valid), int'(m_valid));
      chk(in_ready == (!m_valid || out_ready), "R5 in_ready", int'(in_ready),
          int'(!m_valid || out_ready));
      if (m_valid)
        chk(int'(out_result) == m_data, "R3 out_result", int'(out_result), m_data);
      chk(cmp_event == (m_valid && out_ready && model_hit()), "R9 cmp_event",
          int'(cmp_event), int'(m_valid && out_ready && model_hit()));
      if (out_valid && out_ready) begin
        got_d.push_back(int'(out_result));
        got_e.push_back(cmp_event);
      end
    end
  end

  task automatic send(input int v);
    @(posedge clk); #1;
    in_valid = 1'b1;
    in_sample = 16'(v);
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic expect_res(input int d, input bit e, input string req);
    while (got_d.size() == 0) @(negedge clk);
    begin
      int gd;
      bit ge;
      gd = got_d.pop_front();
      ge = got_e.pop_front();
      chk(gd == d, {req, " result"}, gd, d);
      chk(ge == e, {req, " event"}, int'(ge), int'(e));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog R4 actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(out_valid == 0, "R1 out_valid", int'(out_valid), 0);
    chk(cmp_event == 0, "R1 cmp_event", int'(cmp_event), 0);
    chk(in_ready == 1, "R1 in_ready", int'(in_ready), 1);
    chk(out_result == 0, "R1 out_result", int'(out_result), 0);

    // R2 / R6: one sample, above threshold
    count_sel = 3'd0; cmp_enable = 1; cmp_polarity = 0; cmp_threshold = 16'd1000;
    send(1234);
    expect_res(1234, 1, "R2_R6 single");

    // R2 / R7 / R3: four samples, code changed mid-conversion
    count_sel = 3'd1; cmp_polarity = 1; cmp_threshold = 16'd25;
    send(10);
    count_sel = 3'd0;
    send(20); send(30); send(41);
    expect_res(25, 1, "R2_R7 four");

    // R6: equal to threshold, greater-than test gives no event
    count_sel = 3'd2; cmp_polarity = 0; cmp_threshold = 16'd103;
    for (int i = 0; i < 8; i++) send(100 + i);
    expect_res(103, 0, "R6 equal");

    // R2: codes 6 and 7 take one sample
    count_sel = 3'd6; cmp_enable = 0;
    send(500);
    expect_res(500, 0, "R2 code6");
    count_sel = 3'd7;
    send(7);
    expect_res(7, 0, "R2 code7");

    // R3 / R8: full scale sum, compare disabled
    count_sel = 3'd5; cmp_enable = 0; cmp_polarity = 0; cmp_threshold = 16'd65534;
    for (int i = 0; i < 64; i++) send(65535);
    expect_res(65535, 0, "R3_R8 fullscale");

    // R10: fresh sum after previous conversion
    count_sel = 3'd3; cmp_enable = 1; cmp_polarity = 1; cmp_threshold = 16'd10;
    for (int i = 0; i < 16; i++) send(3 * i);
    expect_res(22, 0, "R10 restart");

    // R3: rounding down over 32 samples
    count_sel = 3'd4; cmp_polarity = 0; cmp_threshold = 16'd999;
    send(1031);
    for (int i = 1; i < 32; i++) send(1000);
    expect_res(1000, 1, "R3 floor");

    // R4 / R5 / R9: back-pressure and captured controls
    out_ready = 0;
    count_sel = 3'd0; cmp_enable = 1; cmp_polarity = 0; cmp_threshold = 16'd50;
    send(77);
    @(posedge clk); #1;
    in_valid = 1'b1; in_sample = 16'd999;
    cmp_polarity = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(in_ready == 0, "R5 blocked", int'(in_ready), 0);
      chk(out_valid == 1, "R4 held", int'(out_valid), 1);
      chk(out_result == 16'd77, "R4 stable", int'(out_result), 77);
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
    out_ready = 1;
    expect_res(77, 1, "R9 captured");
    repeat (4) @(negedge clk);
    chk(got_d.size() == 0, "R9 single handshake", got_d.size(), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule